// File: doc/BRIEF.md
# Banked Chip-Select Address Decoder

This block turns a 32-bit system bus address into a single chip-select line for one of eight external memory banks. Each bank has one 32-bit configuration word that holds an aligned base address, a per-bit compare mask and an enable bit. The decode granularity is 128 KiB, so every window is an aligned power-of-two region of at least that size. When no bank claims a valid access, a miss flag is raised. Software writes and reads the configuration words through a small register port. Writes take effect on the next clock edge. The address decode itself is purely combinational.

Two behaviours are carried over from the bus fabric this decoder serves. The first is a boot-swap strap, sampled while reset is held, which exchanges chip selects 0 and 1. Bank 0's enable bit comes out of reset as the inverse of that strap, so software can detect the swap. The second is a quirk in banks 0 and 1: an all-zero word in either of them captures every access even when its enable bit is clear. Software parks an unused bank 0 or 1 by writing all ones to it, which leaves it matching only the topmost 128 KiB.

Top module: `cs_addr_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bank word is cleared, except bit 0 of bank 0, which is loaded with the inverse of `boot_swap`.
- R2: A write with `cfg_wr_en` high to address 0x100 + 0x10*i (i = 0..7) stores `cfg_wr_data` into bank i at that clock edge, and the new value is visible on `cfg_rd_data` afterwards. A write to any other address changes no bank.
- R3: An enabled bank (bit 0 = 1) matches a valid access when, for every address bit k in 31..17 whose mask bit k-16 (word bits 15..1) is 1, address bit k equals word bit k. Address bits whose mask bit is 0 are ignored, as are address bits 16..0.
- R4: A bank whose enable bit is 0 never matches, except in the case covered by R5.
- R5: If bank 0 or bank 1 holds the all-zero word, that bank matches every valid access regardless of its enable bit.
- R6: When several banks match, only the lowest-numbered one drives its chip select. `cs_n_sel` is never more than one-hot.
- R7: `bus_miss` is 1 exactly when `bus_valid` is 1 and no bank matches. When `bus_valid` is 0, both `cs_sel` and `bus_miss` are 0.
- R8: If `boot_swap` was 1 during reset, a bank 0 match drives `cs_sel[1]` and a bank 1 match drives `cs_sel[0]`. Otherwise bank i drives `cs_sel[i]`.
- R9: The all-ones word in bank 0 or 1 matches only addresses 0xFFFE0000..0xFFFFFFFF.
- R10: `boot_swap` is sampled only while `rst_n` is low. Changes after reset do not alter the chip-select mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap | input | 1 | Strap that exchanges chip selects 0 and 1, sampled in reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 12 | Configuration write byte address |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_addr | input | 12 | Configuration read byte address |
| cfg_rd_data | output | 32 | Bank word at `cfg_rd_addr`, or 0 if the address is not a bank word |
| bus_valid | input | 1 | System bus access present |
| bus_addr | input | 32 | System bus byte address |
| cs_sel | output | 8 | One-hot chip-select vector, active high |
| bus_miss | output | 1 | Valid access matched by no bank |

## Verification
`cs_sel`, `bus_miss` and `cfg_rd_data` are combinational, so they are due in the same cycle the inputs change. The bench drives inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A configuration write and the strap capture take effect at the first rising edge after they are driven. Checks that depend on them therefore follow that edge and are made at the next falling edge. Ignored writes are confirmed by reading back all eight bank words.

// File: rtl/cs_dec_pkg.sv
// Package: shared sizes and the bank word layout for the chip-select decoder.
// Assumes a 32-bit bus address and a power-of-two register stride.
package cs_dec_pkg;
    parameter int N_BANKS   = 8;
    parameter int ADDR_W    = 32;
    parameter int GRAN_LSB  = 17;           // 128 KiB decode granularity
    parameter int CFG_AW    = 12;
    parameter int REG_BASE  = 'h100;
    parameter int REG_STEP  = 'h10;

    localparam int CMP_W    = ADDR_W - GRAN_LSB;   // compared address bits
    localparam int IDX_W    = $clog2(N_BANKS);
    localparam int STEP_LG  = $clog2(REG_STEP);

    typedef logic [ADDR_W-1:0] word_t;

    // Base field of a bank word.
    function automatic logic [CMP_W-1:0] word_base(input word_t w);
        return w[ADDR_W-1:GRAN_LSB];
    endfunction

    // Mask field: bits CMP_W..1, mask bit j guards address bit j+GRAN_LSB.
    function automatic logic [CMP_W-1:0] word_mask(input word_t w);
        return w[CMP_W:1];
    endfunction
endpackage

// File: rtl/cs_bank_regs.sv
// Bank configuration register file.
// Holds one word per bank, decodes the write and read addresses, and
// applies the reset value, which depends on the boot-swap strap.
// Assumes a synchronous active-low reset and a single write port.
module cs_bank_regs
    import cs_dec_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      boot_swap,
    input  logic                      wr_en,
    input  logic [CFG_AW-1:0]         wr_addr,
    input  logic [ADDR_W-1:0]         wr_data,
    input  logic [CFG_AW-1:0]         rd_addr,
    output logic [ADDR_W-1:0]         rd_data,
    output logic [N_BANKS-1:0][ADDR_W-1:0] banks
);
    logic [CFG_AW-1:0] wr_off, rd_off;
    logic              wr_hit, rd_hit;
    logic [CFG_AW-STEP_LG-1:0] wr_slot, rd_slot;

    // Decode the write address into a bank slot.
    always_comb begin
        wr_off  = wr_addr - CFG_AW'(REG_BASE);
        wr_slot = wr_off[CFG_AW-1:STEP_LG];
        wr_hit  = (wr_addr >= CFG_AW'(REG_BASE)) &&
                  (wr_off[STEP_LG-1:0] == '0) &&
                  (wr_slot < (CFG_AW-STEP_LG)'(N_BANKS));
    end

    // Decode the read address into a bank slot.
    always_comb begin
        rd_off  = rd_addr - CFG_AW'(REG_BASE);
        rd_slot = rd_off[CFG_AW-1:STEP_LG];
        rd_hit  = (rd_addr >= CFG_AW'(REG_BASE)) &&
                  (rd_off[STEP_LG-1:0] == '0) &&
                  (rd_slot < (CFG_AW-STEP_LG)'(N_BANKS));
    end

    // Read mux: an unmapped address returns zero.
    always_comb begin
        rd_data = '0;
        if (rd_hit)
            rd_data = banks[rd_slot[IDX_W-1:0]];
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_BANKS; gi++) begin : g_bank
            // One bank word: reset value, then load on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    banks[gi] <= '0;
                    if (gi == 0)
                        banks[gi][0] <= ~boot_swap;
                end else if (wr_en && wr_hit && (wr_slot[IDX_W-1:0] == IDX_W'(gi))) begin
                    banks[gi] <= wr_data;
                end
            end

            // R2: an addressed write lands in this bank at the next edge.
            assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_hit && wr_slot[IDX_W-1:0] == IDX_W'(gi))
                |=> (banks[gi] == $past(wr_data)));

            // R2: a write elsewhere leaves this bank unchanged.
            assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_hit && wr_slot[IDX_W-1:0] == IDX_W'(gi))
                |=> $stable(banks[gi]));
        end
    endgenerate
endmodule

// File: rtl/cs_bank_match.sv
// Per-bank window comparators.
// Each bank matches on a masked compare of the upper address bits. Banks
// below ZERO_CAP_N also match on any valid access while their word is zero.
// Purely combinational.
module cs_bank_match
    import cs_dec_pkg::*;
#(
    parameter int ZERO_CAP_N = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          valid,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [N_BANKS-1:0][ADDR_W-1:0] banks,
    output logic [N_BANKS-1:0]            hit
);
    genvar gi;
    generate
        for (gi = 0; gi < N_BANKS; gi++) begin : g_cmp
            logic [CMP_W-1:0] diff;
            logic             win_hit;
            logic             zero_cap;

            // Masked window compare for this bank.
            always_comb begin
                diff    = (addr[ADDR_W-1:GRAN_LSB] ^ word_base(banks[gi])) & word_mask(banks[gi]);
                win_hit = banks[gi][0] && (diff == '0);
            end

            if (gi < ZERO_CAP_N) begin : g_cap
                // A zero word captures every access.
                always_comb zero_cap = (banks[gi] == '0);
            end else begin : g_nocap
                // No capture quirk for this bank.
                always_comb zero_cap = 1'b0;
            end

            // Final hit, gated by the access strobe.
            always_comb hit[gi] = valid && (win_hit || zero_cap);

            if (gi >= ZERO_CAP_N) begin : g_chk
                // R4: a disabled upper bank never matches.
                assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    !banks[gi][0] |-> !hit[gi]);
            end
        end
    endgenerate
endmodule

// File: rtl/cs_prio_swap.sv
// Priority select and chip-select mapping.
// Keeps only the lowest-numbered hit, then exchanges outputs 0 and 1 when
// the captured strap is set. Assumes at least two banks.
module cs_prio_swap
    import cs_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               swap,
    input  logic [N_BANKS-1:0] hit,
    output logic [N_BANKS-1:0] cs
);
    logic [N_BANKS-1:0] win;

    // Lowest-index hit wins.
    always_comb begin
        win = '0;
        for (int i = N_BANKS - 1; i >= 0; i--)
            if (hit[i]) win = N_BANKS'(1) << i;
    end

    // Route bank 0 and bank 1 according to the strap.
    always_comb begin
        cs = win;
        if (swap) begin
            cs[0] = win[1];
            cs[1] = win[0];
        end
    end

    // R6: never more than one chip select.
    assert_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));

    // R6: a select is produced whenever some bank hit.
    assert_some_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> (cs != '0));
endmodule

// File: rtl/cs_addr_decoder.sv
// Top level of the banked chip-select decoder.
// Captures the boot-swap strap in reset, holds the bank words, and decodes
// each bus access into a one-hot chip select or a miss. The decode path is
// combinational; configuration writes land at the next clock edge.
module cs_addr_decoder
    import cs_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_swap,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_wr_addr,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic [CFG_AW-1:0] cfg_rd_addr,
    output logic [ADDR_W-1:0] cfg_rd_data,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [N_BANKS-1:0] cs_sel,
    output logic              bus_miss
);
    logic                          swap_q;
    logic [N_BANKS-1:0][ADDR_W-1:0] banks;
    logic [N_BANKS-1:0]            hit;

    // Strap capture: follows the pin only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) swap_q <= boot_swap;
    end

    cs_bank_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_swap(boot_swap),
        .wr_en    (cfg_wr_en),
        .wr_addr  (cfg_wr_addr),
        .wr_data  (cfg_wr_data),
        .rd_addr  (cfg_rd_addr),
        .rd_data  (cfg_rd_data),
        .banks    (banks)
    );

    cs_bank_match #(.ZERO_CAP_N(2)) u_match (
        .clk  (clk),
        .rst_n(rst_n),
        .valid(bus_valid),
        .addr (bus_addr),
        .banks(banks),
        .hit  (hit)
    );

    cs_prio_swap u_prio (
        .clk  (clk),
        .rst_n(rst_n),
        .swap (swap_q),
        .hit  (hit),
        .cs   (cs_sel)
    );

    // Miss flag: a valid access that no bank claimed.
    always_comb bus_miss = bus_valid && (hit == '0);

    // R7: miss and chip select are mutually exclusive on a valid access.
    assert_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_miss == (cs_sel == '0)));

    // R7: no output activity without an access.
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (cs_sel == '0 && !bus_miss));

    // R10: the captured strap does not move outside reset.
    assert_strap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(swap_q));
endmodule

// File: tb/test_cs_addr_decoder.sv
module test_cs_addr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_swap = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [11:0] cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [11:0] cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  cs_sel;
    logic        bus_miss;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    cs_addr_decoder i_cs_addr_decoder (
        .clk(clk), .rst_n(rst_n), .boot_swap(boot_swap),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .bus_valid(bus_valid), .bus_addr(bus_addr),
        .cs_sel(cs_sel), .bus_miss(bus_miss)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; boot_swap = strap; bus_valid = 1'b0; cfg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int bank, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 12'(12'h100 + 12'h10 * bank); cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int bank, input logic [31:0] exp);
        cfg_rd_addr = 12'(12'h100 + 12'h10 * bank);
        #1;
        check(req, cfg_rd_data, exp);
    endtask

    task automatic dec_check(input string req, input logic [31:0] a,
                             input logic [7:0] exp_cs, input logic exp_miss);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a;
        #1;
        check(req, {24'h0, cs_sel}, {24'h0, exp_cs});
        check(req, {31'h0, bus_miss}, {31'h0, exp_miss});
    endtask

    task automatic t_reset_plain;
        do_reset(1'b0);
        @(negedge clk);
        rd_check("R1", 0, 32'h1);
        for (int b = 1; b < 8; b++) rd_check("R1", b, 32'h0);
        dec_check("R3", 32'h1234_5678, 8'h01, 1'b0);  // bank0 enabled, mask zero
    endtask

    task automatic t_windows;
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        rd_check("R2", 0, 32'hFFFF_FFFF);
        dec_check("R9", 32'h1000_0000, 8'h00, 1'b1);
        dec_check("R9", 32'hFFFE_0000, 8'h01, 1'b0);
        dec_check("R9", 32'hFFFD_FFFF, 8'h00, 1'b1);
        wr(2, 32'h4000_FFF1);   // 1 MiB window at 0x4000_0000
        dec_check("R3", 32'h400F_FFFF, 8'h04, 1'b0);
        dec_check("R3", 32'h4010_0000, 8'h00, 1'b1);
        wr(3, 32'h4000_FFFF);   // 128 KiB window inside bank 2
        dec_check("R6", 32'h4000_0000, 8'h04, 1'b0);
        wr(4, 32'h5000_FFFE);   // disabled
        dec_check("R4", 32'h5000_0000, 8'h00, 1'b1);
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 32'h4000_0000;
        #1;
        check("R7", {23'h0, cs_sel, bus_miss}, 32'h0);
    endtask

    task automatic t_ignored_writes;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 12'h104; cfg_wr_data = 32'h0;
        @(negedge clk);
        cfg_wr_addr = 12'h180;
        @(negedge clk);
        cfg_wr_addr = 12'h0F0;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        rd_check("R2", 0, 32'hFFFF_FFFF);
        rd_check("R2", 1, 32'hFFFF_FFFF);
        rd_check("R2", 2, 32'h4000_FFF1);
        rd_check("R2", 3, 32'h4000_FFFF);
        rd_check("R2", 4, 32'h5000_FFFE);
        for (int b = 5; b < 8; b++) rd_check("R2", b, 32'h0);
    endtask

    task automatic t_zero_capture;
        wr(1, 32'h0);
        dec_check("R5", 32'h1234_5678, 8'h02, 1'b0);
        dec_check("R5", 32'h4000_0000, 8'h02, 1'b0);
        dec_check("R6", 32'hFFFF_0000, 8'h01, 1'b0);
    endtask

    task automatic t_swap;
        do_reset(1'b1);
        @(negedge clk);
        rd_check("R1", 0, 32'h0);
        dec_check("R8", 32'h0000_1000, 8'h02, 1'b0);
        boot_swap = 1'b0;
        repeat (2) @(negedge clk);
        dec_check("R10", 32'h0000_1000, 8'h02, 1'b0);
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'h2000_FFFF);
        dec_check("R8", 32'h2000_0000, 8'h01, 1'b0);
        dec_check("R8", 32'hFFFE_0000, 8'h02, 1'b0);
    endtask

    initial begin
        t_reset_plain();
        t_windows();
        t_ignored_writes();
        t_zero_capture();
        t_swap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule